// File: doc/BRIEF.md
# Receive Bit-Error Checker with Sync Monitor

This block checks a received serial test pattern for bit errors. It keeps a local 32-bit copy of the pattern generator and compares each enabled bit on the data input with the bit that copy predicts. The generator copy can produce a pseudorandom sequence x^n + x^y + 1, a repetitive pattern of length n, or the quasi-random variant with fixed taps and forced ones.

While the block is out of sync, it fills the local register with the received bits for n enabled bits and then starts checking. While checking, it keeps a sliding window of the last 64 per-bit error flags. It drops back to seeding once that window holds six or more errors.

It counts the received bits and the in-sync mismatches. A performance-monitor strobe moves both running totals into holding outputs and restarts the counters. A status flag shows whether the running error counter is non-zero.

Top module: `bert_rx_check`

## Requirements
- R1: After reset `outOfSync` is 1, `errSeen` is 0 and both `bitHold` and `errHold` are 0.
- R2: After a load, `outOfSync` falls at the clock edge that takes the n-th enabled bit, where `lenSel` = n-1. That bit is the last seed bit, and checking starts with the next enabled bit.
- R3: In pseudorandom mode (`repMode`=0, `qrssOn`=0), each expected bit is the XOR of the bits received n and y bits earlier, with `tapSel` = y-1. A clean stream of this kind gives no errors.
- R4: In repetitive mode (`repMode`=1), the expected bit equals the bit from n bits earlier. A clean repeating pattern gives no errors, and each flipped bit counts exactly one error.
- R5: In pseudorandom and quasi-random modes, the expected bit is 1 when the 31 newest reference bits are all zero. Repetitive mode has no such guard.
- R6: With `qrssOn`=1, the feedback is the XOR of reference bits 17 and 20, counted from 1 at the newest bit. The expected bit is forced to 1 when the 14 newest reference bits are all zero.
- R7: While in sync, an error that brings the errors among the last 64 checked bits to 6 sets `outOfSync` at that edge. Five errors do not set it, and errors older than 64 checked bits no longer count.
- R8: Mismatches on bits received while `outOfSync` is 1 are not added to the error count.
- R9: A `pmUpdate` pulse copies the running bit and error totals into `bitHold` and `errHold` and restarts both counters. A bit or an error that arrives in the same cycle is counted in the new interval.
- R10: `errSeen` is 1 exactly when the running error counter is non-zero.
- R11: The bit and error counters saturate at all ones and do not wrap.
- R12: A load happens only on a 0-to-1 change of `loadReq` while `testerOn` is 1. While `testerOn` is 0, bits are neither counted nor checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testerOn | input | 1 | Enables checking, counting and loading |
| loadReq | input | 1 | Reload control; its rising edge restarts the seeding |
| bitEn | input | 1 | Marks a cycle that carries a received bit |
| rxBit | input | 1 | Received serial data |
| lenSel | input | 5 | Pattern length n minus 1 |
| tapSel | input | 5 | Tap position y minus 1 |
| repMode | input | 1 | 1 = repetitive pattern |
| qrssOn | input | 1 | 1 = quasi-random mode with fixed taps and forcing |
| pmUpdate | input | 1 | Performance-monitor snapshot strobe |
| outOfSync | output | 1 | 1 while seeding or after loss of sync |
| errSeen | output | 1 | Running error counter is non-zero |
| bitHold | output | CNT_W | Bit total of the last closed interval |
| errHold | output | CNT_W | Error total of the last closed interval |

## Verification
The hardest case to reach from the ports is the sliding window. It must count errors that are spread across it, and it must let go of errors that have slid out of it. Errors are injected at fixed spacings into a stream the bench generates itself. Ten errors spread over more than 64 bits must not cause a loss of sync, while six errors inside 51 bits must. A one-bit slip in the stream drives the checker out of sync in a natural way, so that errors against its stale reference can be shown not to count during the reseed.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  localparam int REF_W = 32;
  localparam int SEL_W = $clog2(REF_W);
  localparam int QRSS_TAP_A = 16;
  localparam int QRSS_TAP_B = 19;
  localparam int QRSS_ZERO_RUN = 14;

  typedef struct packed {
    logic loadRef;
    logic seedBit;
    logic checkBit;
    logic clrWin;
    logic countBit;
    logic snap;
  } dpCtl_t;
endpackage

// File: rtl/bert_rx_ctrl.sv
module bert_rx_ctrl
  import bert_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             testerOn,
  input  logic             loadReq,
  input  logic             bitEn,
  input  logic             pmUpdate,
  input  logic [SEL_W-1:0] lenSel,
  input  logic             lossNext,
  output dpCtl_t           ctl,
  output logic             outOfSync
);
  logic             loadPrev;
  logic [SEL_W-1:0] seedCnt;
  logic             loadRise;
  logic             active;
  logic             seedDone;

  assign loadRise = testerOn & loadReq & ~loadPrev;
  assign active   = testerOn & bitEn;
  assign seedDone = (seedCnt == lenSel);

  always_comb begin
    ctl          = '0;
    ctl.snap     = pmUpdate;
    ctl.countBit = active;
    if (loadRise) begin
      ctl.loadRef = 1'b1;
      ctl.clrWin  = 1'b1;
    end else if (active) begin
      if (outOfSync) begin
        ctl.seedBit = 1'b1;
        ctl.clrWin  = seedDone;
      end else begin
        ctl.checkBit = 1'b1;
        ctl.clrWin   = lossNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPrev  <= 1'b0;
      seedCnt   <= '0;
      outOfSync <= 1'b1;
    end else begin
      loadPrev <= loadReq;
      if (loadRise) begin
        outOfSync <= 1'b1;
        seedCnt   <= '0;
      end else if (active) begin
        if (outOfSync) begin
          if (seedDone) begin
            outOfSync <= 1'b0;
            seedCnt   <= '0;
          end else begin
            seedCnt <= seedCnt + SEL_W'(1);
          end
        end else if (lossNext) begin
          outOfSync <= 1'b1;
          seedCnt   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bert_rx_path.sv
module bert_rx_path
  import bert_rx_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_LIM = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             rxBit,
  input  logic [SEL_W-1:0] lenSel,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             repMode,
  input  logic             qrssOn,
  output logic             lossNext,
  output logic             errSeen,
  output logic [CNT_W-1:0] bitHold,
  output logic [CNT_W-1:0] errHold
);
  localparam int POP_W = $clog2(WIN_LEN + 1);

  logic [REF_W-1:0]   refReg;
  logic [WIN_LEN-1:0] win;
  logic [POP_W-1:0]   popCnt;
  logic [POP_W-1:0]   popNext;
  logic [CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   errCnt;
  logic               fbRaw;
  logic               fb;
  logic               expBit;
  logic               errNow;
  logic               countErr;

  always_comb begin
    if (qrssOn)       fbRaw = refReg[QRSS_TAP_A] ^ refReg[QRSS_TAP_B];
    else if (repMode) fbRaw = refReg[lenSel];
    else              fbRaw = refReg[lenSel] ^ refReg[tapSel];
    fb     = (!repMode || qrssOn) && (refReg[REF_W-2:0] == '0) ? 1'b1 : fbRaw;
    expBit = (qrssOn && (refReg[QRSS_ZERO_RUN-1:0] == '0)) ? 1'b1 : fb;
  end

  assign errNow   = rxBit ^ expBit;
  assign countErr = ctl.checkBit & errNow;
  assign popNext  = popCnt + POP_W'(errNow) - POP_W'(win[WIN_LEN-1]);
  assign lossNext = (popNext >= POP_W'(LOSS_LIM));
  assign errSeen  = (errCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refReg <= '1;
    end else if (ctl.loadRef) begin
      refReg <= '1;
    end else if (ctl.seedBit) begin
      refReg <= {refReg[REF_W-2:0], rxBit};
    end else if (ctl.checkBit) begin
      refReg <= {refReg[REF_W-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrWin) begin
      win    <= '0;
      popCnt <= '0;
    end else if (ctl.checkBit) begin
      win    <= {win[WIN_LEN-2:0], errNow};
      popCnt <= popNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      errCnt  <= '0;
      bitHold <= '0;
      errHold <= '0;
    end else if (ctl.snap) begin
      bitHold <= bitCnt;
      errHold <= errCnt;
      bitCnt  <= CNT_W'(ctl.countBit);
      errCnt  <= CNT_W'(countErr);
    end else begin
      if (ctl.countBit && (bitCnt != '1)) bitCnt <= bitCnt + CNT_W'(1);
      if (countErr && (errCnt != '1))     errCnt <= errCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bert_rx_check.sv
module bert_rx_check
  import bert_rx_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_LIM = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testerOn,
  input  logic             loadReq,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic [SEL_W-1:0] lenSel,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             repMode,
  input  logic             qrssOn,
  input  logic             pmUpdate,
  output logic             outOfSync,
  output logic             errSeen,
  output logic [CNT_W-1:0] bitHold,
  output logic [CNT_W-1:0] errHold
);
  dpCtl_t ctl;
  logic   lossNext;

  bert_rx_ctrl ctrl (
    .clk(clk), .rstN(rstN), .testerOn(testerOn), .loadReq(loadReq),
    .bitEn(bitEn), .pmUpdate(pmUpdate), .lenSel(lenSel),
    .lossNext(lossNext), .ctl(ctl), .outOfSync(outOfSync)
  );

  bert_rx_path #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN), .LOSS_LIM(LOSS_LIM)) path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit), .lenSel(lenSel),
    .tapSel(tapSel), .repMode(repMode), .qrssOn(qrssOn),
    .lossNext(lossNext), .errSeen(errSeen), .bitHold(bitHold), .errHold(errHold)
  );
endmodule

// File: rtl/bert_rx_check_sva.sv
module bert_rx_check_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             testerOn,
  input logic             bitEn,
  input logic             pmUpdate,
  input logic             outOfSync,
  input logic             errSeen,
  input logic [CNT_W-1:0] bitHold,
  input logic [CNT_W-1:0] errHold
);
  // R9 / R10: a strobe with no bit leaves the new interval without errors
  a_r9_snap_clears: assert property (@(posedge clk) disable iff (!rstN)
    (pmUpdate && !(testerOn && bitEn)) |=> !errSeen);

  // R8: nothing is counted while the reference is being seeded
  a_r8_no_count_unsynced: assert property (@(posedge clk) disable iff (!rstN)
    (outOfSync && !errSeen) |=> !errSeen);

  // R2: sync is only gained on an enabled bit
  a_r2_sync_on_bit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outOfSync) |-> ($past(bitEn) && $past(testerOn)));

  // R12: an idle tester changes neither state nor held totals
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!testerOn && !pmUpdate) |=> ($stable(outOfSync) && $stable(bitHold) && $stable(errHold)));

  // R7: loss of sync only follows an enabled cycle
  a_r7_loss_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outOfSync) |-> $past(testerOn));
endmodule

bind bert_rx_check bert_rx_check_sva #(.CNT_W(CNT_W)) sva (
  .clk(clk), .rstN(rstN), .testerOn(testerOn), .bitEn(bitEn),
  .pmUpdate(pmUpdate), .outOfSync(outOfSync), .errSeen(errSeen),
  .bitHold(bitHold), .errHold(errHold)
);

// File: tb/bert_rx_check_test.sv
`timescale 1ns/1ps
module bert_rx_check_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN, testerOn, loadReq, bitEn, rxBit, repMode, qrssOn, pmUpdate;
  logic [4:0] lenSel, tapSel;
  logic outOfSync, errSeen;
  logic [CW-1:0] bitHold, errHold;

  int total = 0;
  int bad = 0;
  int nVal, yVal;
  logic [63:0] hist;

  always #4 clk = ~clk;

  bert_rx_check #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .testerOn(testerOn), .loadReq(loadReq),
    .bitEn(bitEn), .rxBit(rxBit), .lenSel(lenSel), .tapSel(tapSel),
    .repMode(repMode), .qrssOn(qrssOn), .pmUpdate(pmUpdate),
    .outOfSync(outOfSync), .errSeen(errSeen), .bitHold(bitHold), .errHold(errHold)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // next bit of the transmitted stream: x^n + x^y + 1, or repeat of bit n
  task automatic genBit(output logic b);
    if (repMode) b = hist[nVal-1];
    else         b = hist[nVal-1] ^ hist[yVal-1];
    hist = {hist[62:0], b};
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitEn = 1'b1; rxBit = b;
    @(posedge clk); #1;
    bitEn = 1'b0;
  endtask

  task automatic pulseUpdate();
    @(negedge clk);
    pmUpdate = 1'b1;
    @(posedge clk); #1;
    pmUpdate = 1'b0;
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    loadReq = 1'b1;
    @(posedge clk); #1;
    loadReq = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic setCfg(int n, int y, logic rep, logic q, logic [63:0] seed);
    nVal = n; yVal = y;
    lenSel = 5'(n - 1); tapSel = 5'(y - 1);
    repMode = rep; qrssOn = q; hist = seed;
  endtask

  task automatic sendClean(int cnt);
    logic b;
    for (int i = 0; i < cnt; i++) begin
      genBit(b); sendBit(b);
    end
  endtask

  task automatic resync(string req);
    pulseLoad();
    chk({req, " load -> out of sync"}, outOfSync, 1);
    sendClean(nVal - 1);
    chk({req, " still seeding before n-th bit"}, outOfSync, 1);
    sendClean(1);
    chk({req, " in sync after n bits"}, outOfSync, 0);
  endtask

  task automatic testReset();
    chk("R1 outOfSync", outOfSync, 1);
    chk("R1 errSeen", errSeen, 0);
    chk("R1 bitHold", int'(bitHold), 0);
    chk("R1 errHold", int'(errHold), 0);
  endtask

  task automatic testPrbsClean();
    setCfg(9, 5, 1'b0, 1'b0, 64'h1A5);
    resync("R2");
    pulseUpdate();
    sendClean(100);
    chk("R3 no errors on clean stream", errSeen, 0);
    pulseUpdate();
    chk("R3 bit total", int'(bitHold), 100);
    chk("R3 error total", int'(errHold), 0);
  endtask

  task automatic testRepetitive();
    logic b;
    setCfg(8, 1, 1'b1, 1'b0, 64'h0F);
    resync("R4");
    pulseUpdate();
    for (int i = 0; i < 40; i++) begin
      genBit(b); sendBit((i == 20) ? ~b : b);
    end
    chk("R10 errSeen after one error", errSeen, 1);
    pulseUpdate();
    chk("R4 one error counted", int'(errHold), 1);
    chk("R10 errSeen cleared by update", errSeen, 0);
  endtask

  task automatic testExactLoss();
    logic b;
    setCfg(9, 5, 1'b0, 1'b0, 64'h0F3);
    resync("R7");
    pulseUpdate();
    for (int i = 0; i <= 50; i++) begin
      genBit(b); sendBit((i % 10 == 0) ? ~b : b);
      if (i == 40) chk("R7 five errors keep sync", outOfSync, 0);
    end
    chk("R7 sixth error drops sync", outOfSync, 1);
    pulseUpdate();
    chk("R7 six errors counted", int'(errHold), 6);
  endtask

  task automatic testSlide();
    logic b;
    setCfg(9, 5, 1'b0, 1'b0, 64'h155);
    resync("R7");
    pulseUpdate();
    for (int i = 0; i <= 145; i++) begin
      genBit(b);
      sendBit(((i <= 40 && i % 10 == 0) || (i >= 105 && i % 10 == 5)) ? ~b : b);
    end
    chk("R7 old errors leave the window", outOfSync, 0);
    pulseUpdate();
    chk("R7 ten spread errors counted", int'(errHold), 10);
  endtask

  task automatic testSlipNoCount();
    logic b;
    int guard;
    setCfg(9, 5, 1'b0, 1'b0, 64'h0C3);
    resync("R8");
    sendClean(20);
    genBit(b);
    guard = 0;
    while (!outOfSync && guard < 300) begin
      genBit(b); sendBit(b); guard++;
    end
    chk("R7 slip causes loss", outOfSync, 1);
    pulseUpdate();
    chk("R7 at least six errors before loss", int'(errHold >= 6), 1);
    sendClean(nVal);
    chk("R8 reseeded", outOfSync, 0);
    sendClean(50);
    pulseUpdate();
    chk("R8 no errors counted while out of sync", int'(errHold), 0);
  endtask

  task automatic testUpdateCollision();
    logic b;
    setCfg(9, 5, 1'b0, 1'b0, 64'h0B1);
    resync("R9");
    pulseUpdate();
    sendClean(5);
    genBit(b); sendBit(~b);
    sendClean(5);
    genBit(b); sendBit(~b);
    sendClean(5);
    genBit(b);
    @(negedge clk);
    bitEn = 1'b1; rxBit = ~b; pmUpdate = 1'b1;
    @(posedge clk); #1;
    bitEn = 1'b0; pmUpdate = 1'b0;
    chk("R9 held errors from old interval", int'(errHold), 2);
    chk("R9 held bits from old interval", int'(bitHold), 17);
    chk("R10 coincident error in new interval", errSeen, 1);
    pulseUpdate();
    chk("R9 coincident error carried", int'(errHold), 1);
    chk("R9 coincident bit carried", int'(bitHold), 1);
  endtask

  task automatic testSaturate();
    logic b;
    setCfg(9, 5, 1'b0, 1'b0, 64'h0E7);
    resync("R11");
    pulseUpdate();
    for (int i = 0; i < 65 * 64; i++) begin
      genBit(b); sendBit((i % 16 == 0) ? ~b : b);
    end
    chk("R11 sync kept at four per window", outOfSync, 0);
    pulseUpdate();
    chk("R11 bit count saturates", int'(bitHold), 255);
    chk("R11 error count saturates", int'(errHold), 255);
  endtask

  task automatic testGuard();
    setCfg(31, 28, 1'b0, 1'b0, 64'h1);
    pulseLoad();
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    pulseUpdate();
    sendBit(1'b0);
    pulseUpdate();
    chk("R5 all-zero guard forces one", int'(errHold), 1);
    setCfg(31, 28, 1'b1, 1'b0, 64'h1);
    pulseLoad();
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    pulseUpdate();
    sendBit(1'b0);
    pulseUpdate();
    chk("R5 no guard in repetitive mode", int'(errHold), 0);
  endtask

  task automatic testQrss();
    setCfg(20, 17, 1'b0, 1'b1, 64'h1);
    pulseLoad();
    for (int i = 0; i < 20; i++) sendBit(1'b0);
    pulseUpdate();
    sendBit(1'b0);
    pulseUpdate();
    chk("R6 zero run forces one", int'(errHold), 1);
    setCfg(20, 17, 1'b0, 1'b0, 64'h1);
    pulseLoad();
    for (int i = 0; i < 20; i++) sendBit(1'b0);
    pulseUpdate();
    sendBit(1'b0);
    pulseUpdate();
    chk("R6 plain mode expects zero", int'(errHold), 0);
  endtask

  task automatic testLoadGate();
    setCfg(9, 5, 1'b0, 1'b0, 64'h0A7);
    resync("R12");
    pulseUpdate();
    testerOn = 1'b0;
    pulseLoad();
    chk("R12 load ignored while off", outOfSync, 0);
    sendBit(1'b1);
    sendBit(1'b0);
    testerOn = 1'b1;
    pulseUpdate();
    chk("R12 bits ignored while off", int'(bitHold), 0);
    chk("R12 state kept while off", outOfSync, 0);
    pulseLoad();
    chk("R12 rising load while on", outOfSync, 1);
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; testerOn = 1'b1; loadReq = 1'b0; bitEn = 1'b0; rxBit = 1'b0;
    pmUpdate = 1'b0; repMode = 1'b0; qrssOn = 1'b0; lenSel = '0; tapSel = '0;
    nVal = 9; yVal = 5; hist = 64'h1;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrbsClean();
    testRepetitive();
    testExactLoss();
    testSlide();
    testSlipNoCount();
    testUpdateCollision();
    testSaturate();
    testGuard();
    testQrss();
    testLoadGate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule